// File: doc/BRIEF.md
# Periodic Row Padding Streamer

This block sits in front of a horizontal FIR filter with an odd tap count and widens every raster row so that the filter window never runs off the row's edges. Let EXT be (TAPS-1)/2. After each row's last sample, the block replays that row's first EXT samples. Before each row, it emits the last EXT samples of the row above. The padding therefore wraps around between neighbouring rows. It is built in one causal pass and holds only a few samples, not a frame.

The first row of a frame has no row above it. A parameter sets how its leading pad is formed. In the cheap variant the row's first sample is repeated EXT times. In the buffered variant the whole row is captured first, and its own last EXT samples are then used. The last row of a frame carries the frame-end marker on its final trailing pad sample. The row after that opens a new frame.

Both sides use a valid/ready handshake with a row-start flag and a frame-end flag. Input is taken only while row samples pass straight through. While pad samples are being emitted, in_ready stays low.

Top module: `rowext_stream`

## Requirements
- R1: Each output row is, in order: EXT leading pad samples, the ROW_W input samples of the row unchanged and in order, then EXT trailing pad samples. An output row is therefore ROW_W+2*EXT beats long, where EXT=(TAPS-1)/2.
- R2: The trailing pad of a row is that row's own column 0 to EXT-1 samples, in ascending column order.
- R3: For every row except the first of a frame, the leading pad is the previous row's columns ROW_W-EXT to ROW_W-1, in ascending column order.
- R4: With FIRST_OWN=0, the leading pad of a frame's first row is EXT copies of that row's column 0 sample. That sample is consumed only as the first body beat.
- R5: With FIRST_OWN=1, a frame's first row is accepted in full, with out_valid low, before any of it is emitted. Its leading pad is its own columns ROW_W-EXT to ROW_W-1.
- R6: in_ready is high only when the offered output is the live input sample, and then it equals out_ready. It is low throughout every pad beat and throughout the buffered replay of R5.
- R7: out_sor is high exactly on the first leading pad beat of each row. out_eof is high exactly on the last trailing pad beat of the row whose final input sample carried in_eof. in_sor marks column 0 of every input row.
- R8: After the out_eof beat, the next row is treated as the first row of a new frame. It takes no pad from the previous frame.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change on the next cycle.
- R10: After reset, with no input offered: for FIRST_OWN=0, out_valid and in_ready are both low; for FIRST_OWN=1, in_ready is high and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample accepted this cycle when in_valid is high |
| in_data | input | DATA_W | Input pixel |
| in_sor | input | 1 | Input sample is column 0 of a row |
| in_eof | input | 1 | Input sample is the last of the frame |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | DATA_W | Output pixel, padded stream |
| out_sor | output | 1 | First beat of an output row |
| out_eof | output | 1 | Last beat of a frame |

## Verification
If the column counter slips, the row length and the in_sor alignment both go wrong. This shows at the next out_sor, and the data of the same row already sits in the wrong segment. A wrong capture index in a pad bank shows up at the trailing pad of that same row, or at the leading pad of the next row. This happens within EXT beats of the row edge. A lost frame-end or first-row flag corrupts the first leading pad of the following frame.

// File: rtl/rowext_pkg.sv
package rowext_pkg;
  typedef enum logic [1:0] {PH_FILL, PH_LEAD, PH_BODY, PH_TRAIL} phase_e;
  typedef enum logic [1:0] {SRC_LIVE, SRC_TAILQ, SRC_HEADQ, SRC_ROWQ} src_e;
endpackage

// File: rtl/rowext_bank.sv
module rowext_bank #(
  parameter int DW    = 8,
  parameter int DEPTH = 2,
  parameter int AW    = 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/rowext_seq.sv
module rowext_seq
  import rowext_pkg::*;
#(
  parameter int ROW_W     = 16,
  parameter int EXT       = 2,
  parameter bit FIRST_OWN = 1'b0,
  localparam int CW = $clog2(ROW_W),
  localparam int IW = (EXT > 1) ? $clog2(EXT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_eof,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          out_sor,
  output logic          out_eof,
  output src_e          src,
  output logic [CW-1:0] col,
  output logic [IW-1:0] idx,
  output logic          head_we,
  output logic          tail_we,
  output logic          row_we,
  output logic [IW-1:0] head_widx,
  output logic [IW-1:0] tail_widx
);
  localparam logic [CW-1:0] COL_LAST = CW'(ROW_W - 1);
  localparam logic [CW-1:0] COL_TAIL = CW'(ROW_W - EXT);
  localparam logic [CW-1:0] COL_HEAD = CW'(EXT);
  localparam logic [IW-1:0] IDX_LAST = IW'(EXT - 1);
  localparam phase_e        START_PH = FIRST_OWN ? PH_FILL : PH_LEAD;

  phase_e        ph, ph_n;
  logic [CW-1:0] col_n;
  logic [IW-1:0] idx_n;
  logic          first_row, first_n;
  logic          replay, replay_n;
  logic          last_row, last_n;
  logic          accept;

  always_comb begin
    ph_n      = ph;
    col_n     = col;
    idx_n     = idx;
    first_n   = first_row;
    replay_n  = replay;
    last_n    = last_row;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_sor   = 1'b0;
    out_eof   = 1'b0;
    src       = SRC_LIVE;
    case (ph)
      PH_FILL: begin
        in_ready = 1'b1;
        if (in_valid) begin
          col_n = col + 1'b1;
          if (col == COL_LAST) begin
            col_n    = '0;
            last_n   = in_eof;
            replay_n = 1'b1;
            ph_n     = PH_LEAD;
          end
        end
      end
      PH_LEAD: begin
        out_sor = (idx == '0);
        if (first_row && !replay) begin
          src       = SRC_LIVE;
          out_valid = in_valid;
        end else begin
          src       = SRC_TAILQ;
          out_valid = 1'b1;
        end
        if (out_valid && out_ready) begin
          idx_n = idx + 1'b1;
          if (idx == IDX_LAST) begin
            idx_n = '0;
            ph_n  = PH_BODY;
          end
        end
      end
      PH_BODY: begin
        if (replay) begin
          src       = SRC_ROWQ;
          out_valid = 1'b1;
        end else begin
          src       = SRC_LIVE;
          out_valid = in_valid;
          in_ready  = out_ready;
        end
        if (out_valid && out_ready) begin
          col_n = col + 1'b1;
          if (col == COL_LAST) begin
            col_n = '0;
            ph_n  = PH_TRAIL;
            if (!replay) last_n = in_eof;
          end
        end
      end
      default: begin
        src       = SRC_HEADQ;
        out_valid = 1'b1;
        out_eof   = last_row && (idx == IDX_LAST);
        if (out_ready) begin
          idx_n = idx + 1'b1;
          if (idx == IDX_LAST) begin
            idx_n    = '0;
            replay_n = 1'b0;
            first_n  = last_row;
            last_n   = 1'b0;
            ph_n     = last_row ? START_PH : PH_LEAD;
          end
        end
      end
    endcase
  end

  assign accept    = in_valid && in_ready;
  assign head_we   = accept && (col < COL_HEAD);
  assign tail_we   = accept && (col >= COL_TAIL);
  assign row_we    = accept && (ph == PH_FILL);
  assign head_widx = IW'(col);
  assign tail_widx = IW'(col - COL_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= START_PH;
      col       <= '0;
      idx       <= '0;
      first_row <= 1'b1;
      replay    <= 1'b0;
      last_row  <= 1'b0;
    end else begin
      ph        <= ph_n;
      col       <= col_n;
      idx       <= idx_n;
      first_row <= first_n;
      replay    <= replay_n;
      last_row  <= last_n;
    end
  end

  // R1
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col <= COL_LAST);
endmodule

// File: rtl/rowext_stream.sv
module rowext_stream
  import rowext_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int TAPS      = 5,
  parameter int ROW_W     = 16,
  parameter bit FIRST_OWN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sor,
  input  logic              in_eof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sor,
  output logic              out_eof
);
  localparam int EXT     = (TAPS - 1) / 2;
  localparam int CW      = $clog2(ROW_W);
  localparam int IW      = (EXT > 1) ? $clog2(EXT) : 1;
  localparam int ROW_LEN = ROW_W + 2 * EXT;
  localparam int LW      = $clog2(ROW_LEN + 1);

  src_e              src;
  logic [CW-1:0]     col;
  logic [IW-1:0]     idx;
  logic              head_we, tail_we, row_we;
  logic [IW-1:0]     head_widx, tail_widx;
  logic [DATA_W-1:0] head_rd, tail_rd, row_rd;

  rowext_seq #(.ROW_W(ROW_W), .EXT(EXT), .FIRST_OWN(FIRST_OWN)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
    .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
    .out_sor(out_sor), .out_eof(out_eof), .src(src), .col(col), .idx(idx),
    .head_we(head_we), .tail_we(tail_we), .row_we(row_we),
    .head_widx(head_widx), .tail_widx(tail_widx)
  );

  rowext_bank #(.DW(DATA_W), .DEPTH(EXT), .AW(IW)) u_head (
    .clk(clk), .we(head_we), .wr_idx(head_widx), .wr_data(in_data),
    .rd_idx(idx), .rd_data(head_rd)
  );

  rowext_bank #(.DW(DATA_W), .DEPTH(EXT), .AW(IW)) u_tail (
    .clk(clk), .we(tail_we), .wr_idx(tail_widx), .wr_data(in_data),
    .rd_idx(idx), .rd_data(tail_rd)
  );

  generate
    if (FIRST_OWN) begin : g_rowbuf
      rowext_bank #(.DW(DATA_W), .DEPTH(ROW_W), .AW(CW)) u_row (
        .clk(clk), .we(row_we), .wr_idx(col), .wr_data(in_data),
        .rd_idx(col), .rd_data(row_rd)
      );
    end else begin : g_norowbuf
      assign row_rd = '0;
      wire unused_row_we = row_we;
    end
  endgenerate

  always_comb begin
    case (src)
      SRC_TAILQ: out_data = tail_rd;
      SRC_HEADQ: out_data = head_rd;
      SRC_ROWQ:  out_data = row_rd;
      default:   out_data = in_data;
    endcase
  end

  wire unused_sor_in = in_sor;

  logic          out_fire;
  logic [LW-1:0] beat_cnt;
  logic          seen_row;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      seen_row <= 1'b0;
    end else if (out_fire) begin
      beat_cnt <= out_sor ? LW'(1) : beat_cnt + 1'b1;
      seen_row <= seen_row | out_sor;
    end
  end

  // R1
  row_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_sor && seen_row |-> beat_cnt == LW'(ROW_LEN));
  // R7
  eof_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_eof |-> beat_cnt == LW'(ROW_LEN - 1));
  // R7
  sor_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> in_sor == (col == '0));
  // R6
  live_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && in_ready |-> out_data == in_data);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !in_ready |=> out_valid && $stable(out_data));
endmodule

// File: tb/rowext_stream_test.sv
module rowext_stream_test;
  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int TAPS  = 5;
  localparam int W     = 6;
  localparam int E     = (TAPS - 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  logic b_valid = 1'b0, b_sor = 1'b0, b_eof = 1'b0, b_ready = 1'b0;
  logic [DW-1:0] b_data = '0;

  logic ir_a, ov_a, os_a, oe_a, ir_b, ov_b, os_b, oe_b;
  logic [DW-1:0] od_a, od_b;

  always #(CLK_P/2) clk = ~clk;

  rowext_stream #(.DATA_W(DW), .TAPS(TAPS), .ROW_W(W), .FIRST_OWN(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(b_valid & ~sel), .in_ready(ir_a),
    .in_data(b_data), .in_sor(b_sor), .in_eof(b_eof), .out_valid(ov_a),
    .out_ready(b_ready & ~sel), .out_data(od_a), .out_sor(os_a), .out_eof(oe_a));

  rowext_stream #(.DATA_W(DW), .TAPS(TAPS), .ROW_W(W), .FIRST_OWN(1'b1)) uut_own (
    .clk(clk), .rst_n(rst_n), .in_valid(b_valid & sel), .in_ready(ir_b),
    .in_data(b_data), .in_sor(b_sor), .in_eof(b_eof), .out_valid(ov_b),
    .out_ready(b_ready & sel), .out_data(od_b), .out_sor(os_b), .out_eof(oe_b));

  wire          m_ir = sel ? ir_b : ir_a;
  wire          m_ov = sel ? ov_b : ov_a;
  wire          m_os = sel ? os_b : os_a;
  wire          m_oe = sel ? oe_b : oe_a;
  wire [DW-1:0] m_od = sel ? od_b : od_a;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int unsigned rs = 32'h1234_5678;

  logic [DW-1:0] exp_d [0:255];
  bit            exp_s [0:255];
  bit            exp_e [0:255];
  int            exp_seg [0:255];
  bit            exp_rep [0:255];
  int            exp_need [0:255];
  string         exp_tag [0:255];
  int            exp_n;
  int            rec_n;

  function automatic bit rbit();
    rs = rs * 32'd1103515245 + 32'd12345;
    return rs[16];
  endfunction

  function automatic logic [DW-1:0] pix(input int f, input int r, input int c);
    return DW'(f * 37 + r * 11 + c * 3 + 5);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic build(input bit own, input int nfr, input int nrows);
    exp_n = 0;
    for (int f = 0; f < nfr; f++) begin
      for (int r = 0; r < nrows; r++) begin
        for (int k = 0; k < E; k++) begin
          if (r == 0) exp_d[exp_n] = own ? pix(f, 0, W - E + k) : pix(f, 0, 0);
          else        exp_d[exp_n] = pix(f, r - 1, W - E + k);
          exp_tag[exp_n]  = (r != 0) ? "R3" : (f > 0) ? "R8" : own ? "R5" : "R4";
          exp_s[exp_n]    = (k == 0);
          exp_e[exp_n]    = 1'b0;
          exp_seg[exp_n]  = 0;
          exp_rep[exp_n]  = own && (r == 0);
          exp_need[exp_n] = (own && r == 0) ? f * nrows * W + W : 0;
          exp_n++;
        end
        for (int c = 0; c < W; c++) begin
          exp_d[exp_n]    = pix(f, r, c);
          exp_tag[exp_n]  = "R1";
          exp_s[exp_n]    = 1'b0;
          exp_e[exp_n]    = 1'b0;
          exp_seg[exp_n]  = 1;
          exp_rep[exp_n]  = own && (r == 0);
          exp_need[exp_n] = 0;
          exp_n++;
        end
        for (int k = 0; k < E; k++) begin
          exp_d[exp_n]    = pix(f, r, k);
          exp_tag[exp_n]  = "R2";
          exp_s[exp_n]    = 1'b0;
          exp_e[exp_n]    = (r == nrows - 1) && (k == E - 1);
          exp_seg[exp_n]  = 2;
          exp_rep[exp_n]  = own && (r == 0);
          exp_need[exp_n] = 0;
          exp_n++;
        end
      end
    end
  endtask

  task automatic run_frames(input bit own, input int nfr, input int nrows, input bit stall);
    int total_in, ptr, cyc, fi, ri, ci;
    bit acc_prev, stall_prev;
    logic [DW-1:0] prev_data;
    build(own, nfr, nrows);
    total_in = nfr * nrows * W;
    ptr = 0; cyc = 0; rec_n = 0;
    acc_prev = 1'b0; stall_prev = 1'b0; prev_data = '0;
    sel = own;
    while ((ptr < total_in || rec_n < exp_n) && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (acc_prev) begin ptr++; b_valid = 1'b0; end
      if (!b_valid && ptr < total_in && (!stall || rbit())) b_valid = 1'b1;
      if (ptr < total_in) begin
        fi = ptr / (nrows * W);
        ri = (ptr / W) % nrows;
        ci = ptr % W;
        b_data = pix(fi, ri, ci);
        b_sor  = (ci == 0);
        b_eof  = (ri == nrows - 1) && (ci == W - 1);
      end
      b_ready = stall ? (rbit() | rbit()) : 1'b1;
      #(CLK_P/4);
      if (stall_prev) begin
        chk(m_ov == 1'b1, "R9", "valid held under stall", m_ov, 1);
        chk(m_od == prev_data, "R9", "data held under stall", m_od, prev_data);
      end
      if (m_ov && m_ir)
        chk(rec_n < exp_n && exp_seg[rec_n] == 1 && !exp_rep[rec_n], "R6",
            "in_ready high on non-live beat", rec_n, -1);
      if (m_ov && rec_n < exp_n && exp_need[rec_n] > 0)
        chk(ptr >= exp_need[rec_n], "R5", "inputs taken before first-row output",
            ptr, exp_need[rec_n]);
      if (m_ov && b_ready) begin
        if (rec_n < exp_n) begin
          chk(m_od == exp_d[rec_n], exp_tag[rec_n], $sformatf("data beat %0d", rec_n),
              m_od, exp_d[rec_n]);
          chk(m_os == exp_s[rec_n], "R7", $sformatf("out_sor beat %0d", rec_n),
              m_os, exp_s[rec_n]);
          chk(m_oe == exp_e[rec_n], "R7", $sformatf("out_eof beat %0d", rec_n),
              m_oe, exp_e[rec_n]);
        end else begin
          chk(1'b0, "R1", "extra output beat", rec_n, exp_n);
        end
        rec_n++;
      end
      stall_prev = m_ov && !b_ready;
      prev_data  = m_od;
      acc_prev   = b_valid && m_ir;
    end
    @(negedge clk);
    if (acc_prev) ptr++;
    b_valid = 1'b0;
    b_ready = 1'b0;
    chk(rec_n == exp_n, "R1", "output beat count", rec_n, exp_n);
    chk(ptr == total_in, "R1", "input samples taken", ptr, total_in);
  endtask

  // R10
  task automatic test_reset();
    sel = 1'b0; b_valid = 1'b0; b_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #(CLK_P/4);
    chk(m_ov == 1'b0, "R10", "replicate out_valid after reset", m_ov, 0);
    chk(m_ir == 1'b0, "R10", "replicate in_ready after reset", m_ir, 0);
    sel = 1'b1;
    #(CLK_P/8);
    chk(m_ov == 1'b0, "R10", "buffered out_valid after reset", m_ov, 0);
    chk(m_ir == 1'b1, "R10", "buffered in_ready after reset", m_ir, 1);
    @(negedge clk);
    sel = 1'b0; b_ready = 1'b0;
  endtask

  // R1 R2 R3 R4 R7 on a clean stream
  task automatic test_replicate_plain();
    run_frames(1'b0, 1, 3, 1'b0);
  endtask

  // R8 R9 R6 with gaps and back-pressure, two frames back to back
  task automatic test_replicate_stall();
    run_frames(1'b0, 2, 3, 1'b1);
  endtask

  // R4 R7: single-row frame, first row is also last
  task automatic test_single_row();
    run_frames(1'b0, 1, 1, 1'b0);
  endtask

  // R5 on a clean stream
  task automatic test_own_plain();
    run_frames(1'b1, 1, 2, 1'b0);
  endtask

  // R5 R8 R9 with stalls, two frames
  task automatic test_own_stall();
    run_frames(1'b1, 2, 3, 1'b1);
  endtask

  initial begin
    test_reset();
    test_replicate_plain();
    test_replicate_stall();
    test_single_row();
    test_own_plain();
    test_own_stall();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 60000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule